// File: doc/BRIEF.md
# Count-Leading-Zeros Word Execution Unit

This unit executes one integer instruction of a 64-bit register machine whose bits are numbered from the most significant end, so bit 0 is the MSB. Each transfer carries a 32-bit instruction word, the 64-bit source operand and the current summary-overflow flag. The unit decodes the word and checks whether it is the X-form count-leading-zeros-word instruction. For a match it counts the leading zero bits of the operand's low 32-bit half. The count runs from 0 to 32 and is returned zero-extended to 64 bits, together with the destination register index. In record form the unit also builds a 4-bit condition field by comparing the result against zero as a signed number.

Both edges of the unit use a valid/ready handshake. An input transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer directly. While `out_valid` is high and `out_ready` is low, every output holds its value. A word that does not match still produces an output transfer, but with both write enables low, so the result stays in order with the surrounding stream.

Top module: `clzw_unit`

## Requirements
- R1: A word with primary opcode 31 (instruction bits 0–5, Verilog `in_instr[31:26]`) and 10-bit extended opcode 26 (bits 21–30, `in_instr[10:1]`) matches, and the base word with the record bit clear is 0x7C000034. A match drives `out_gpr_we`=1, with `out_dest` taken from instruction bits 11–15 (`in_instr[20:16]`).
- R2: Any other word still produces an output transfer, with `out_gpr_we`=0 and `out_cr_we`=0.
- R3: `out_result` holds the number of leading zeros of operand bits 32–63 (`in_src[31:0]`), counted from operand bit 32. Result bits 0–57 (`out_result[63:6]`) are zero.
- R4: Operand bits 0–31 (`in_src[63:32]`) have no effect on any output.
- R5: A low word of all zeros gives a result of 32, whatever the upper half holds.
- R6: When operand bit 32 (`in_src[31]`) is set, the result is 0.
- R7: When the record bit (instruction bit 31, `in_instr[0]`) is 1 on a match, `out_cr_we`=1 and `out_cr` = {LT,GT,EQ,SO} from MSB to LSB. LT is always 0. EQ=1 and GT=0 when the count is 0, and GT=1 and EQ=0 otherwise. SO equals `in_so`.
- R8: When the record bit is 0, `out_cr_we`=0.
- R9: An accepted input appears on the outputs, with `out_valid`=1, in the cycle after the accepting clock edge.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, all outputs hold their values.
- R11: After reset, `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Unit can accept an input this cycle |
| in_instr | input | 32 | Instruction word |
| in_src | input | 64 | Source register value |
| in_so | input | 1 | Summary-overflow flag |
| out_valid | output | 1 | Output transfer offered |
| out_ready | input | 1 | Consumer accepts the output |
| out_dest | output | 5 | Destination register index |
| out_result | output | 64 | Zero-extended count |
| out_gpr_we | output | 1 | Register write enable |
| out_cr_we | output | 1 | Condition-field write enable |
| out_cr | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
A single set bit is walked across all 64 operand positions. In the low half this proves every count from 0 to 31. In the upper half it proves that those bits are ignored and give 32. Operands made of pseudo-random values with junk in the upper half, an all-zero low word and a set low-word MSB separate a correct priority encoder from one that counts the wrong half or misses the boundary values. Words differing from a match only in the primary or extended opcode show that decoding is exact, and alternating the record bit and the overflow flag, under irregular consumer back-pressure, proves the condition field and the holding of outputs.

// File: rtl/clzw_pkg.sv
package clzw_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int XO_W    = 10;
  localparam int RIDX_W  = 5;

  localparam logic [OPC_W-1:0] OPC_MATCH = 6'd31;
  localparam logic [XO_W-1:0]  XO_MATCH  = 10'd26;

  // Field positions in Verilog numbering (bit 0 = LSB).
  localparam int OPC_LSB  = 26;
  localparam int SRC_LSB  = 21;
  localparam int DST_LSB  = 16;
  localparam int XO_LSB   = 1;
  localparam int REC_BIT  = 0;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;

  typedef struct packed {
    logic              hit;
    logic              rec;
    logic [RIDX_W-1:0] dst;
  } dec_t;
endpackage

// File: rtl/clzw_decode.sv
module clzw_decode
  import clzw_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [OPC_W-1:0] opc;
  logic [XO_W-1:0]  xo;

  always_comb begin
    opc     = instr[OPC_LSB +: OPC_W];
    xo      = instr[XO_LSB +: XO_W];
    dec.hit = (opc == OPC_MATCH) && (xo == XO_MATCH);
    dec.rec = instr[REC_BIT];
    dec.dst = instr[DST_LSB +: RIDX_W];
  end
endmodule

// File: rtl/clzw_lzcount.sv
module clzw_lzcount #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word,
  output logic [CW-1:0] cnt
);
  // Priority encoder: the highest set bit wins, so scan upward and overwrite.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (word[i]) cnt = CW'(W - 1 - i);
    end
  end

  always_comb begin
    // R6
    msb_zero_chk: assert (!word[W-1] || cnt == '0);
    // R5
    empty_full_chk: assert (word != '0 || cnt == CW'(W));
  end
endmodule

// File: rtl/clzw_crgen.sv
module clzw_crgen
  import clzw_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0] cnt,
  input  logic          so,
  output crf_t          crf
);
  // The count is never negative, so only GT or EQ can be set.
  always_comb begin
    crf.lt = 1'b0;
    crf.eq = (cnt == '0);
    crf.gt = (cnt != '0);
    crf.so = so;
  end
endmodule

// File: rtl/clzw_unit.sv
module clzw_unit
  import clzw_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int WORD_W = 32,
  localparam int CW    = $clog2(WORD_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [REG_W-1:0]   in_src,
  input  logic               in_so,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [RIDX_W-1:0]  out_dest,
  output logic [REG_W-1:0]   out_result,
  output logic               out_gpr_we,
  output logic               out_cr_we,
  output logic [3:0]         out_cr
);
  dec_t          dec;
  logic [CW-1:0] cnt;
  crf_t          crf;

  clzw_decode u_dec (.instr(in_instr), .dec(dec));

  clzw_lzcount #(.W(WORD_W)) u_lz (
    .word (in_src[WORD_W-1:0]),
    .cnt  (cnt)
  );

  clzw_crgen #(.CW(CW)) u_cr (.cnt(cnt), .so(in_so), .crf(crf));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_dest   <= '0;
      out_result <= '0;
      out_gpr_we <= 1'b0;
      out_cr_we  <= 1'b0;
      out_cr     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_dest   <= dec.dst;
        out_result <= {{(REG_W-CW){1'b0}}, cnt};
        out_gpr_we <= dec.hit;
        out_cr_we  <= dec.hit && dec.rec;
        out_cr     <= crf;
      end
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_cr) && $stable(out_dest) && $stable(out_gpr_we) && $stable(out_cr_we));
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R8
  cr_needs_gpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_we |-> out_gpr_we);
  // R7
  cr_no_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_we |-> !out_cr[3] && (out_cr[2] != out_cr[1]));
  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_gpr_we |-> out_result <= REG_W'(WORD_W));
endmodule

// File: tb/tb_clzw_unit.sv
module tb_clzw_unit;
  typedef struct packed {
    logic        gpr_we;
    logic        cr_we;
    logic [4:0]  dest;
    logic [63:0] result;
    logic [3:0]  cr;
    int          acc;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready, in_so = 0, out_valid, out_ready = 1;
  logic [31:0] in_instr = 0;
  logic [63:0] in_src = 0;
  logic [4:0]  out_dest;
  logic [63:0] out_result;
  logic        out_gpr_we, out_cr_we;
  logic [3:0]  out_cr;

  int checks = 0, failures = 0, cyc = 0;
  int rdy_mode = 0;
  bit done = 0;
  exp_t q[$];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  clzw_unit dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_clz(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) if (w[i]) return 31 - i;
    return 32;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [9:0] xo,
                                     input logic [4:0] rs, input logic [4:0] ra, input logic rc);
    return {opc, rs, ra, 5'd0, xo, rc};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ins, input logic [63:0] src, input logic so);
    exp_t e;
    bit   hit;
    int   n;
    @(negedge clk);
    in_valid = 1; in_instr = ins; in_src = src; in_so = so;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    hit = (ins[31:26] == 6'd31) && (ins[10:1] == 10'd26);
    n = ref_clz(src[31:0]);
    e.gpr_we = hit;
    e.cr_we  = hit && ins[0];
    e.dest   = ins[20:16];
    e.result = 64'(n);
    e.cr     = {1'b0, n != 0, n == 0, so};
    e.acc    = cyc;
    q.push_back(e);
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor / scoreboard
  initial begin
    bit fresh = 1, held = 0;
    logic [78:0] snap;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (held) begin
        // R10: outputs hold under back-pressure
        chk(out_valid && snap == {out_dest, out_result, out_gpr_we, out_cr_we, out_cr},
            "R10 hold", {out_gpr_we, out_cr_we, out_result[61:0]}, snap[63:0]);
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[2:0] != 3'd0 && lfsr[4:3] != 2'd0);
      #1;
      // R10: ready relation
      chk(in_ready == (!out_valid || out_ready), "R10 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
      if (out_valid && q.size() > 0) begin
        e = q[0];
        if (fresh) begin
          // R9: one-cycle latency
          chk(cyc == e.acc, "R9 latency", 64'(cyc), 64'(e.acc));
          fresh = 0;
        end
      end
      held = out_valid && !out_ready;
      snap = {out_dest, out_result, out_gpr_we, out_cr_we, out_cr};
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, "R9 unexpected output", 64'(1), 64'(0));
        else begin
          e = q.pop_front();
          chk(out_gpr_we == e.gpr_we, "R1/R2 gpr_we", 64'(out_gpr_we), 64'(e.gpr_we));
          chk(out_cr_we == e.cr_we, "R7/R8 cr_we", 64'(out_cr_we), 64'(e.cr_we));
          if (e.gpr_we) begin
            chk(out_dest == e.dest, "R1 dest", 64'(out_dest), 64'(e.dest));
            chk(out_result == e.result, "R3/R4/R5/R6 result", out_result, e.result);
          end
          if (e.cr_we) chk(out_cr == e.cr, "R7 cr", 64'(out_cr), 64'(e.cr));
        end
        fresh = 1;
      end
    end
  end

  // Watchdog
  initial begin
    wait (cyc > 100000);
    if (!done) begin
      chk(0, "watchdog", 64'(cyc), 64'(0));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] ins;
    repeat (3) @(negedge clk);
    #3;
    // R11
    chk(out_valid == 0, "R11 reset valid", 64'(out_valid), 64'(0));
    rst_n = 1;
    // R1 base word
    chk(mk(6'd31, 10'd26, 5'd0, 5'd0, 1'b0) == 32'h7C000034, "R1 encoding",
        64'(mk(6'd31, 10'd26, 0, 0, 0)), 64'h7C000034);
    drive(32'h7C000034, 64'h0000_0000_0001_0000, 0);                          // R3
    drive(mk(31, 26, 3, 7, 1), 64'hFFFF_FFFF_0000_0000, 1);                   // R5 R4 R7
    drive(mk(31, 26, 4, 9, 1), 64'h0000_0000_8000_0000, 0);                   // R6 R7 EQ
    drive(mk(31, 26, 4, 9, 1), 64'h0000_0000_8000_0000, 1);                   // R7 SO
    drive(mk(31, 26, 1, 31, 0), 64'h1234_5678_0000_0001, 1);                  // R8
    drive(mk(30, 26, 1, 2, 1), 64'h1, 0);                                     // R2
    drive(mk(31, 27, 1, 2, 1), 64'h1, 0);                                     // R2
    drive(mk(31, 10'h21A, 1, 2, 1), 64'h1, 1);                                // R2
    drive(mk(63, 26, 1, 2, 0), 64'h0, 0);                                     // R2
    // Walking one over all 64 positions (R3, R4, R5)
    for (int k = 0; k < 64; k++) drive(mk(31, 26, 5'(k), 5'(k + 3), 1'(k)), 64'd1 << k, 1'(k >> 1));
    // Back-pressure phase with pseudo-random operands
    rdy_mode = 1;
    for (int k = 0; k < 150; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v = {~lfsr, lfsr >> lfsr[4:0]};
      ins = (k % 7 == 3) ? mk(6'(lfsr[5:0]), 10'(lfsr[15:6]), 1, 2, 1) : mk(31, 26, 5'(k), 5'(lfsr[9:5]), lfsr[0]);
      drive(ins, v, lfsr[1]);
      if (lfsr[3]) @(negedge clk);
    end
    rdy_mode = 0;
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9 drained", 64'(q.size()), 64'(0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule